// File: doc/BRIEF.md
# Convolver Configuration Register Interface

This block is the host-side write port that sets up a 3 x 3 image convolver. A processor drives a 3-bit address, an active-low chip select, an active-low load strobe and a data bus. Each completed write lands in one of a small set of configuration registers: the row length, the ALU microcode, the initialization word, or one of two nine-entry coefficient banks. Two addresses carry no data and only choose which coefficient bank feeds the datapath. One address does nothing.

All decoded settings leave the block as registered values synchronous to the datapath clock. A write never takes effect while the load strobe is held low. It commits on the clock edge that first sees the strobe released. A bank switch made during active processing therefore changes the coefficients between two whole cycles. An asynchronous active-low reset restores the power-up defaults.

Top module: `conv_cfg_if`

## Requirements
- R1: While and after reset, row_len_o is 1024, alu_code_o, init_o, casc_ext_o, casc_shift_o and bank_sel_o are 0, all coefficient taps of both banks are 0, and both bank write indices point at tap 0.
- R2: A write is captured on every rising edge that samples cs_ni=0 and ld_ni=0, keeping the address and data of the last such edge. It commits on the first following edge that samples ld_ni=1, and the registers show the new value right after that edge. No register changes on an edge that samples ld_ni=0.
- R3: A load pulse during which cs_ni is sampled high on every edge changes no register.
- R4: Address 0 writes data_i[9:0] to the row length. row_len_o equals that value, except that 0 reads as 1024.
- R5: Address 1 writes data_i[7:0] to alu_code_o.
- R6: Address 2 writes data_i[7:0] into bank 0 and address 3 into bank 1. Each bank has its own index that starts at tap 0 and advances by one per write. After tap 8 the index wraps, so the tenth write overwrites tap 0.
- R7: Address 4 writes data_i[8:0] to init_o. casc_ext_o is bit 0 (0 adds the cascade input, 1 uses it as external row data), and casc_shift_o is bits [8:7].
- R8: Address 5 makes bank 0 active and address 6 makes bank 1 active. Data is ignored and no other register changes. coef_o carries the active bank, with tap k at bits [8k+7:8k].
- R9: Address 7 changes no register.
- R10: Holding the strobe low for several cycles produces exactly one write, with the data of the last captured cycle. A coefficient index advances by only one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Datapath clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ld_ni | input | 1 | Load strobe, active low |
| addr_i | input | 3 | Register address |
| data_i | input | 10 | Write data |
| row_len_o | output | 11 | Effective row length, 1 to 1024 |
| alu_code_o | output | 8 | ALU microcode word |
| init_o | output | 9 | Initialization word |
| casc_ext_o | output | 1 | Cascade input used as external row data |
| casc_shift_o | output | 2 | Cascade input shift selection |
| bank_sel_o | output | 1 | Active coefficient bank |
| coef_o | output | 72 | Active bank taps, tap k at [8k+7:8k] |

## Verification
Every write result is due two edges after the bench first drives both strobes low. The first edge captures the write and the edge that samples the release commits it. The bench drives inputs on falling edges and samples all outputs on the falling edge after the commit edge. For held strobes, the bench compares against the model only after the release edge, and the assertions forbid any change on an edge that sees the strobe low. The model also follows each bank's write index, so wrap-around, bank independence and a reset in the middle of a load sequence are checked against the tap the next write should hit.

// File: rtl/conv_cfg_pkg.sv
package conv_cfg_pkg;
  typedef enum logic [2:0] {
    ADR_ROW_LEN = 3'd0,
    ADR_ALU     = 3'd1,
    ADR_COEF0   = 3'd2,
    ADR_COEF1   = 3'd3,
    ADR_INIT    = 3'd4,
    ADR_SEL0    = 3'd5,
    ADR_SEL1    = 3'd6,
    ADR_NOP     = 3'd7
  } cfg_addr_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/conv_cfg_wr_capture.sv
module conv_cfg_wr_capture #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ld_ni,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [2:0]        wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              pend_q;
  logic [2:0]        addr_q;
  logic [DATA_W-1:0] data_q;

  // Last both-low edge wins (R2); pending cleared on release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!ld_ni && !cs_ni) begin
      pend_q <= 1'b1;
      addr_q <= addr_i;
      data_q <= data_i;
    end else if (ld_ni) begin
      pend_q <= 1'b0;
    end
  end

  // Commit on the edge that samples the strobe released (R2, R10).
  assign wr_o      = pend_q && ld_ni;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/conv_cfg_coef_bank.sv
module conv_cfg_coef_bank #(
  parameter int unsigned COEF_W = 8,
  parameter int unsigned TAPS   = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [COEF_W-1:0]      data_i,
  output logic [TAPS*COEF_W-1:0] taps_o
);
  localparam int unsigned IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAPS - 1);

  logic [IDX_W-1:0] idx_q;

  // Wrapping load index (R6)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idx_q <= '0;
    else if (we_i && idx_q == LAST_IDX) idx_q <= '0;
    else if (we_i)               idx_q <= idx_q + 1'b1;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [COEF_W-1:0] tap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             tap_q <= '0;
      else if (we_i && idx_q == IDX_W'(k))     tap_q <= data_i;
    end
    assign taps_o[k*COEF_W +: COEF_W] = tap_q;
  end
endmodule

// File: rtl/conv_cfg_scalar_regs.sv
module conv_cfg_scalar_regs #(
  parameter int unsigned RL_W   = 10,
  parameter int unsigned ALU_W  = 8,
  parameter int unsigned INIT_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_rl_i,
  input  logic              we_alu_i,
  input  logic              we_init_i,
  input  logic              sel0_i,
  input  logic              sel1_i,
  input  logic [RL_W-1:0]   rl_i,
  input  logic [ALU_W-1:0]  alu_i,
  input  logic [INIT_W-1:0] init_i,
  output logic [RL_W-1:0]   rl_o,
  output logic [ALU_W-1:0]  alu_o,
  output logic [INIT_W-1:0] init_o,
  output logic              bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rl_o   <= '0;   // raw 0 reads as maximum row length (R1, R4)
      alu_o  <= '0;
      init_o <= '0;
      bank_o <= 1'b0;
    end else begin
      if (we_rl_i)   rl_o   <= rl_i;
      if (we_alu_i)  alu_o  <= alu_i;
      if (we_init_i) init_o <= init_i;
      if (sel0_i)      bank_o <= 1'b0;
      else if (sel1_i) bank_o <= 1'b1;
    end
  end
endmodule

// File: rtl/conv_cfg_if.sv
module conv_cfg_if
  import conv_cfg_pkg::*;
#(
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned MAX_ROW   = 1024,
  parameter int unsigned COEF_W    = 8,
  parameter int unsigned ALU_W     = 8,
  parameter int unsigned INIT_W    = 9,
  parameter int unsigned TAPS      = 9,
  parameter int unsigned SHIFT_LSB = 7,
  localparam int unsigned RL_W     = $clog2(MAX_ROW),
  localparam int unsigned COEFS_W  = TAPS * COEF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               ld_ni,
  input  logic [2:0]         addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [RL_W:0]      row_len_o,
  output logic [ALU_W-1:0]   alu_code_o,
  output logic [INIT_W-1:0]  init_o,
  output logic               casc_ext_o,
  output logic [1:0]         casc_shift_o,
  output logic               bank_sel_o,
  output logic [COEFS_W-1:0] coef_o
);
  logic              wr;
  logic [2:0]        wr_addr;
  logic [DATA_W-1:0] wr_data;
  cfg_addr_e         wr_sel;
  logic [RL_W-1:0]   rl_raw;
  logic [NUM_BANKS-1:0] bank_we;
  logic [COEFS_W-1:0]   bank_taps [NUM_BANKS];

  conv_cfg_wr_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .ld_ni     (ld_ni),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .wr_o      (wr),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  assign wr_sel = cfg_addr_e'(wr_addr);

  conv_cfg_scalar_regs #(.RL_W(RL_W), .ALU_W(ALU_W), .INIT_W(INIT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_rl_i   (wr && wr_sel == ADR_ROW_LEN),
    .we_alu_i  (wr && wr_sel == ADR_ALU),
    .we_init_i (wr && wr_sel == ADR_INIT),
    .sel0_i    (wr && wr_sel == ADR_SEL0),
    .sel1_i    (wr && wr_sel == ADR_SEL1),
    .rl_i      (wr_data[RL_W-1:0]),
    .alu_i     (wr_data[ALU_W-1:0]),
    .init_i    (wr_data[INIT_W-1:0]),
    .rl_o      (rl_raw),
    .alu_o     (alu_code_o),
    .init_o    (init_o),
    .bank_o    (bank_sel_o)
  );

  assign bank_we[0] = wr && wr_sel == ADR_COEF0;
  assign bank_we[1] = wr && wr_sel == ADR_COEF1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    conv_cfg_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (bank_we[b]),
      .data_i (wr_data[COEF_W-1:0]),
      .taps_o (bank_taps[b])
    );
  end

  assign coef_o       = bank_sel_o ? bank_taps[1] : bank_taps[0];
  assign row_len_o    = (rl_raw == '0) ? (RL_W+1)'(MAX_ROW) : {1'b0, rl_raw};
  assign casc_ext_o   = init_o[0];
  assign casc_shift_o = init_o[SHIFT_LSB +: 2];
endmodule

// File: rtl/conv_cfg_if_chk.sv
module conv_cfg_if_chk #(
  parameter int unsigned MAX_ROW = 1024,
  parameter int unsigned ALU_W   = 8,
  parameter int unsigned INIT_W  = 9,
  parameter int unsigned COEFS_W = 72,
  parameter int unsigned RL_W    = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_ni,
  input logic               ld_ni,
  input logic [2:0]         addr_i,
  input logic [RL_W:0]      row_len_o,
  input logic [ALU_W-1:0]   alu_code_o,
  input logic [INIT_W-1:0]  init_o,
  input logic               bank_sel_o,
  input logic [COEFS_W-1:0] coef_o
);
  logic [RL_W+ALU_W+INIT_W+COEFS_W+1:0] state;
  assign state = {row_len_o, alu_code_o, init_o, bank_sel_o, coef_o};

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ni |=> $stable(state));

  assert_no_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |-> ##2 $stable(state));

  assert_deselected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ni ##1 cs_ni ##1 ld_ni) |=> $stable(state));

  assert_row_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_len_o != '0 && row_len_o <= (RL_W+1)'(MAX_ROW));

  assert_sel_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_sel_o) |-> $stable({row_len_o, alu_code_o, init_o}));

  assert_nop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ni && !cs_ni && addr_i == 3'd7 ##1 ld_ni) |=> $stable(state));
endmodule

bind conv_cfg_if conv_cfg_if_chk #(
  .MAX_ROW (MAX_ROW),
  .ALU_W   (ALU_W),
  .INIT_W  (INIT_W),
  .COEFS_W (COEFS_W),
  .RL_W    (RL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .ld_ni      (ld_ni),
  .addr_i     (addr_i),
  .row_len_o  (row_len_o),
  .alu_code_o (alu_code_o),
  .init_o     (init_o),
  .bank_sel_o (bank_sel_o),
  .coef_o     (coef_o)
);

// File: tb/tb_conv_cfg_if.sv
module tb_conv_cfg_if;
  localparam int DATA_W = 10;
  localparam int TAPS   = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              cs_n  = 1'b1;
  logic              ld_n  = 1'b1;
  logic [2:0]        addr  = '0;
  logic [DATA_W-1:0] data  = '0;
  logic [10:0]       row_len;
  logic [7:0]        alu_code;
  logic [8:0]        init_w;
  logic              casc_ext;
  logic [1:0]        casc_shift;
  logic              bank_sel;
  logic [71:0]       coef;

  conv_cfg_if dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ld_ni(ld_n), .addr_i(addr),
    .data_i(data), .row_len_o(row_len), .alu_code_o(alu_code), .init_o(init_w),
    .casc_ext_o(casc_ext), .casc_shift_o(casc_shift), .bank_sel_o(bank_sel),
    .coef_o(coef)
  );

  int checks = 0;
  int fails  = 0;

  logic [9:0] m_rl;
  logic [7:0] m_alu;
  logic [8:0] m_init;
  logic       m_bank;
  logic [7:0] m_coef [2][TAPS];
  int         m_idx  [2];

  function automatic void model_reset();
    m_rl = '0; m_alu = '0; m_init = '0; m_bank = 1'b0;
    for (int b = 0; b < 2; b++) begin
      m_idx[b] = 0;
      for (int k = 0; k < TAPS; k++) m_coef[b][k] = '0;
    end
  endfunction

  function automatic void model_write(logic [2:0] a, logic [DATA_W-1:0] d);
    case (a)
      3'd0: m_rl   = d[9:0];
      3'd1: m_alu  = d[7:0];
      3'd2, 3'd3: begin
        m_coef[a-2][m_idx[a-2]] = d[7:0];
        m_idx[a-2] = (m_idx[a-2] == TAPS-1) ? 0 : m_idx[a-2] + 1;
      end
      3'd4: m_init = d[8:0];
      3'd5: m_bank = 1'b0;
      3'd6: m_bank = 1'b1;
      default: ;
    endcase
  endfunction

  function automatic logic [10:0] exp_row_len();
    return (m_rl == 0) ? 11'd1024 : {1'b0, m_rl};
  endfunction

  function automatic logic [71:0] exp_coef();
    logic [71:0] v;
    for (int k = 0; k < TAPS; k++) v[k*8 +: 8] = m_coef[m_bank][k];
    return v;
  endfunction

  task automatic chk(string req, string what, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "row_len",    72'(row_len),    72'(exp_row_len()));
    chk(req, "alu_code",   72'(alu_code),   72'(m_alu));
    chk(req, "init",       72'(init_w),     72'(m_init));
    chk(req, "casc_ext",   72'(casc_ext),   72'(m_init[0]));
    chk(req, "casc_shift", 72'(casc_shift), 72'(m_init[8:7]));
    chk(req, "bank_sel",   72'(bank_sel),   72'(m_bank));
    chk(req, "coef",       coef,            exp_coef());
  endtask

  // Drive on falling edges: capture edge, then release/commit edge.
  task automatic do_write(logic [2:0] a, logic [DATA_W-1:0] d);
    @(negedge clk); cs_n = 1'b0; ld_n = 1'b0; addr = a; data = d;
    @(negedge clk); cs_n = 1'b1; ld_n = 1'b1;
    model_write(a, d);
    @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R4 row length including the zero encoding
    do_write(3'd0, 10'd1023); check_all("R4");
    do_write(3'd0, 10'd1);    check_all("R4");
    do_write(3'd0, 10'd0);    check_all("R4");
    do_write(3'd0, 10'd640);  check_all("R4");
    // R5 ALU microcode
    do_write(3'd1, 10'h3a5);  check_all("R5");
    // R7 init fields
    do_write(3'd4, 10'h181);  check_all("R7");
    do_write(3'd4, 10'h080);  check_all("R7");
    do_write(3'd4, 10'h101);  check_all("R7");

    // R6 fill bank 0, then wrap
    for (int k = 0; k < TAPS; k++) do_write(3'd2, DATA_W'(8'h10 + k));
    check_all("R6");
    do_write(3'd2, 10'h0ee); check_all("R6");
    // R6 bank 1 independent index
    for (int k = 0; k < 4; k++) do_write(3'd3, DATA_W'(8'hc0 + k));
    // R8 switch banks, data ignored
    do_write(3'd6, 10'h3ff); check_all("R8");
    do_write(3'd3, 10'h055); check_all("R6");
    do_write(3'd5, 10'h2aa); check_all("R8");
    // R9 no-op address
    do_write(3'd7, 10'h3ff); check_all("R9");

    // R3 load pulse with chip select high
    @(negedge clk); cs_n = 1'b1; ld_n = 1'b0; addr = 3'd1; data = 10'h0ff;
    @(negedge clk); ld_n = 1'b1;
    @(negedge clk); check_all("R3");

    // R10 / R2 held strobe, data changes, chip select drops before release
    @(negedge clk); cs_n = 1'b0; ld_n = 1'b0; addr = 3'd2; data = 10'h011;
    @(negedge clk); check_all("R2");
    data = 10'h022;
    @(negedge clk); check_all("R2");
    data = 10'h033;
    @(negedge clk); cs_n = 1'b1; data = 10'h044;
    @(negedge clk); ld_n = 1'b1;
    model_write(3'd2, 10'h033);
    @(negedge clk); check_all("R10");
    do_write(3'd2, 10'h077); check_all("R10");

    // R1 reset mid-sequence clears indices
    apply_reset();
    do_write(3'd3, 10'h0a1); do_write(3'd6, 10'h0); check_all("R1");

    // Random mix, R2
    for (int i = 0; i < 400; i++) begin
      logic [2:0]        ra;
      logic [DATA_W-1:0] rd;
      ra = 3'($urandom);
      rd = DATA_W'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk); cs_n = 1'b1; ld_n = 1'b0; addr = ra; data = rd;
        @(negedge clk); ld_n = 1'b1;
        @(negedge clk); check_all("R3");
      end else begin
        do_write(ra, rd);
        check_all("R2");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule